// File: doc/BRIEF.md
# Decimal Field Zero-and-Add Engine

This engine moves one decimal field of a character-addressed store into a second field, which it clears first. Each storage character has seven bits: bit 6 is the word mark, bits 5 and 4 are the B and A zone bits, and bits 3..0 are the 8-4-2-1 numeric bits. Work starts at the units (highest-addressed) position of each field and steps toward lower addresses. Each destination character gets the numeric bits of the source character. When the source runs out, it gets a BCD zero. Only the units position keeps a zone, and that zone carries the sign.

A pulse on `start` begins an operation. The instruction length given with the pulse selects the form. Length 7 (two fields) loads A and B from the address inputs. Length 4 (one field, rewritten in place) loads both registers from the A input. Length 1 (chained) keeps the A and B values left by the previous operation. The engine uses a single memory port with a read latency of one cycle. For each character it performs a source read, a destination read and a destination write. The destination read lets the write keep the destination's word mark. `done` or `error` rises at the end of an operation and stays high until the next accepted start.

Top module: `zadd_engine`

## Requirements
- R1: A start whose `instr_len` is not 1, 4 or 7 ends in `error` with `err_code` = 1. It makes no memory access and leaves both address registers unchanged.
- R2: Both fields are processed from the units position downward. After each character is stored, B is one lower. Each source read lowers A by one.
- R3: The first store into a destination position that holds a word mark is the last store. `done` follows it.
- R4: After a source character with a word mark has been read, each further destination position receives numeric code 1010 with zone 00, and no further source address is read.
- R5: Source characters above the destination's length (at lower addresses) are never read.
- R6: Every stored position except the units position has zone bits 00 and keeps the source numeric bits.
- R7: In the units position, source zone 10 (B only, minus) is stored as 10. Any other zone is stored as 11 (plus). The numeric bits are kept.
- R8: A non-units source character with numeric bits 0000 is stored as 0000 with zone 00, not as a zero.
- R9: A store changes bits 5..0 only. Bit 6 at the destination keeps its previous value. Every write is preceded, in the cycle before, by a read of the same address.
- R10: With length 4, B starts equal to A, so the field is rewritten in place and ends at its high-order word mark.
- R11: If an address is at or above `MEM_SIZE` when it is about to be accessed, the operation stops with `error`. `err_code` is 2 for the A side and 3 for the B side, and the bad address is never driven to memory. A decrement below zero also counts as out of range.
- R12: On completion, A and B each hold one below the last address used in their field. Length 1 starts from the existing register values and ignores the address inputs.
- R13: `done` and `error` are never high together. Each stays high until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| instr_len | input | 3 | Instruction length: 1, 4 or 7 |
| a_addr_in | input | ADDR_W | Source units address for lengths 4 and 7 |
| b_addr_in | input | ADDR_W | Destination units address for length 7 |
| a_reg | output | ADDR_W | A address register |
| b_reg | output | ADDR_W | B address register |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 7 | Write character {word mark, B, A, 8, 4, 2, 1} |
| mem_rdata | input | 7 | Read character, valid one cycle after a read |
| done | output | 1 | Operation finished, held until next start |
| error | output | 1 | Operation aborted, held until next start |
| err_code | output | 2 | 0 none, 1 length, 2 A address, 3 B address |

## Verification
Two functions can land on the same character: sensing the source word mark, which starts zero insertion, and storing into the destination word mark, which ends the operation. Both happen on one character when the fields have equal length, and always in the one-field form. In that case the operation must stop after that store, with no zero written below the field, no extra source read and A left exactly one below the mark. The bench provokes the clash with the in-place and chained runs. It judges them from the final memory image, a per-address count of reads and the register values. Separate runs with a shorter source and a longer source cover each function acting alone.

// File: rtl/zadd_pkg.sv
package zadd_pkg;

    typedef struct packed {
        logic       wm;
        logic       zb;
        logic       za;
        logic [3:0] num;
    } mchar_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_A,
        ST_READ_B,
        ST_WRITE_B,
        ST_DONE,
        ST_ERROR
    } st_t;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_LEN  = 2'd1,
        ERR_A    = 2'd2,
        ERR_B    = 2'd3
    } err_t;

    typedef enum logic [1:0] {
        FORM_BAD,
        FORM_CHAIN,
        FORM_ONE,
        FORM_TWO
    } form_t;

    localparam logic [3:0] BCD_ZERO  = 4'b1010;
    localparam logic [1:0] ZONE_NEG  = 2'b10;
    localparam logic [1:0] ZONE_POS  = 2'b11;

    // Strip zones; the units position keeps a normalised sign.
    function automatic logic [5:0] strip_zone(input logic [5:0] raw, input logic units);
        logic [1:0] z;
        z = raw[5:4];
        if (!units)
            return {2'b00, raw[3:0]};
        else if (z == ZONE_NEG)
            return {ZONE_NEG, raw[3:0]};
        else
            return {ZONE_POS, raw[3:0]};
    endfunction

endpackage

// File: rtl/zadd_len_decode.sv
module zadd_len_decode
    import zadd_pkg::*;
(
    input  logic [2:0] len,
    output form_t      form
);
    always_comb begin
        unique case (len)
            3'd1:    form = FORM_CHAIN;
            3'd4:    form = FORM_ONE;
            3'd7:    form = FORM_TWO;
            default: form = FORM_BAD;
        endcase
    end
endmodule

// File: rtl/zadd_char_xform.sv
module zadd_char_xform
    import zadd_pkg::*;
(
    input  logic [5:0] raw,
    input  logic       units,
    output logic [5:0] cooked
);
    always_comb cooked = strip_zone(raw, units);
endmodule

// File: rtl/zadd_addr_regs.sv
module zadd_addr_regs #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_a,
    input  logic [ADDR_W-1:0] load_b,
    input  logic              dec_a,
    input  logic              dec_b,
    output logic [ADDR_W-1:0] a_q,
    output logic [ADDR_W-1:0] b_q
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= load_a;
            b_q <= load_b;
        end else begin
            if (dec_a) a_q <= a_q - ONE;
            if (dec_b) b_q <= b_q - ONE;
        end
    end
endmodule

// File: rtl/zadd_ctrl.sv
module zadd_ctrl
    import zadd_pkg::*;
#(
    parameter int MEM_SIZE = 4000,
    parameter int ADDR_W   = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  form_t             form,
    input  logic [ADDR_W-1:0] a_q,
    input  logic [ADDR_W-1:0] b_q,
    input  logic              rd_wm,
    input  logic [5:0]        xf_data,
    output logic              units,
    output logic              go,
    output logic              dec_a,
    output logic              dec_b,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [6:0]        mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [1:0]        err_code
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MEM_SIZE);

    st_t        st;
    err_t       err;
    logic       a_done;
    logic       fetched;
    logic [5:0] src_q;
    logic       a_ok, b_ok, idle_like;

    assign a_ok      = (a_q < LIMIT);
    assign b_ok      = (b_q < LIMIT);
    assign idle_like = (st == ST_IDLE) || (st == ST_DONE) || (st == ST_ERROR);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            err     <= ERR_NONE;
            units   <= 1'b0;
            a_done  <= 1'b0;
            fetched <= 1'b0;
            src_q   <= '0;
        end else begin
            unique case (st)
                ST_IDLE, ST_DONE, ST_ERROR: begin
                    if (start) begin
                        if (form == FORM_BAD) begin
                            st  <= ST_ERROR;
                            err <= ERR_LEN;
                        end else begin
                            st     <= ST_READ_A;
                            err    <= ERR_NONE;
                            units  <= 1'b1;
                            a_done <= 1'b0;
                        end
                    end
                end
                ST_READ_A: begin
                    if (!a_ok) begin
                        st  <= ST_ERROR;
                        err <= ERR_A;
                    end else begin
                        st      <= ST_READ_B;
                        fetched <= 1'b1;
                    end
                end
                ST_READ_B: begin
                    if (!b_ok) begin
                        st  <= ST_ERROR;
                        err <= ERR_B;
                    end else begin
                        st <= ST_WRITE_B;
                        if (fetched) begin
                            src_q  <= xf_data;
                            a_done <= rd_wm;
                        end else begin
                            src_q <= {2'b00, BCD_ZERO};
                        end
                    end
                end
                ST_WRITE_B: begin
                    units <= 1'b0;
                    if (rd_wm) begin
                        st <= ST_DONE;
                    end else if (a_done) begin
                        st      <= ST_READ_B;
                        fetched <= 1'b0;
                    end else begin
                        st <= ST_READ_A;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        go        = start && idle_like && (form != FORM_BAD);
        dec_a     = (st == ST_READ_A) && a_ok;
        dec_b     = (st == ST_WRITE_B);
        mem_en    = ((st == ST_READ_A) && a_ok) || ((st == ST_READ_B) && b_ok) || (st == ST_WRITE_B);
        mem_we    = (st == ST_WRITE_B);
        mem_addr  = (st == ST_READ_A) ? a_q : b_q;
        mem_wdata = {rd_wm, src_q};
        busy      = !idle_like;
        done      = (st == ST_DONE);
        error     = (st == ST_ERROR);
        err_code  = err;
    end
endmodule

// File: rtl/zadd_engine.sv
module zadd_engine
    import zadd_pkg::*;
#(
    parameter int MEM_SIZE = 4000,
    parameter int ADDR_W   = $clog2(MEM_SIZE) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        instr_len,
    input  logic [ADDR_W-1:0] a_addr_in,
    input  logic [ADDR_W-1:0] b_addr_in,
    output logic [ADDR_W-1:0] a_reg,
    output logic [ADDR_W-1:0] b_reg,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [6:0]        mem_wdata,
    input  logic [6:0]        mem_rdata,
    output logic              done,
    output logic              error,
    output logic [1:0]        err_code
);
    form_t             form;
    logic              units, go, dec_a, dec_b, busy;
    logic [5:0]        xf_data;
    logic [ADDR_W-1:0] load_a, load_b;
    mchar_t            rd_char;

    assign rd_char = mchar_t'(mem_rdata);

    zadd_len_decode u_len (
        .len  (instr_len),
        .form (form)
    );

    zadd_char_xform u_xf (
        .raw    ({rd_char.zb, rd_char.za, rd_char.num}),
        .units  (units),
        .cooked (xf_data)
    );

    always_comb begin
        unique case (form)
            FORM_TWO: begin load_a = a_addr_in; load_b = b_addr_in; end
            FORM_ONE: begin load_a = a_addr_in; load_b = a_addr_in; end
            default:  begin load_a = a_reg;     load_b = b_reg;     end
        endcase
    end

    zadd_addr_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .load   (go),
        .load_a (load_a),
        .load_b (load_b),
        .dec_a  (dec_a),
        .dec_b  (dec_b),
        .a_q    (a_reg),
        .b_q    (b_reg)
    );

    zadd_ctrl #(.MEM_SIZE(MEM_SIZE), .ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .form      (form),
        .a_q       (a_reg),
        .b_q       (b_reg),
        .rd_wm     (rd_char.wm),
        .xf_data   (xf_data),
        .units     (units),
        .go        (go),
        .dec_a     (dec_a),
        .dec_b     (dec_b),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done),
        .error     (error),
        .err_code  (err_code)
    );
endmodule

// File: rtl/zadd_engine_chk.sv
module zadd_engine_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [2:0]        instr_len,
    input logic              busy,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rd_wm,
    input logic [ADDR_W-1:0] b_reg,
    input logic              done,
    input logic              error,
    input logic [1:0]        err_code
);
    a_r1_bad_len: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && instr_len != 3'd1 && instr_len != 3'd4 && instr_len != 3'd7)
        |=> (error && err_code == 2'd1 && !mem_en));

    a_r2_b_steps: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (b_reg == ($past(b_reg) - ADDR_W'(1))));

    a_r3_mark_ends: assert property (@(posedge clk) disable iff (rst)
        (mem_we && rd_wm) |=> (done && !mem_en));

    a_r9_read_before_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(mem_en) && !$past(mem_we) && $past(mem_addr) == mem_addr));

    a_r13_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    a_r13_done_held: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    a_r13_error_held: assert property (@(posedge clk) disable iff (rst)
        (error && !start) |=> error);
endmodule

bind zadd_engine zadd_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .instr_len (instr_len),
    .busy      (busy),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .rd_wm     (mem_rdata[6]),
    .b_reg     (b_reg),
    .done      (done),
    .error     (error),
    .err_code  (err_code)
);

// File: tb/zadd_engine_tb.sv
module zadd_engine_tb;
    localparam int MEM    = 200;
    localparam int ADDR_W = $clog2(MEM) + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [2:0]        instr_len = 3'd0;
    logic [ADDR_W-1:0] a_addr_in = '0, b_addr_in = '0;
    logic [ADDR_W-1:0] a_reg, b_reg, mem_addr;
    logic              mem_en, mem_we, done, error;
    logic [6:0]        mem_wdata, mem_rdata;
    logic [1:0]        err_code;

    logic [6:0] mem [MEM];
    int rd_cnt [MEM];
    int acc_total, wr_total;
    int checks = 0, errors = 0, cyc = 0;

    always #10 clk = ~clk;

    zadd_engine #(.MEM_SIZE(MEM)) u_dut (
        .clk(clk), .rst(rst), .start(start), .instr_len(instr_len),
        .a_addr_in(a_addr_in), .b_addr_in(b_addr_in),
        .a_reg(a_reg), .b_reg(b_reg),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .error(error), .err_code(err_code)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            acc_total <= acc_total + 1;
            if (int'(mem_addr) < MEM) begin
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    wr_total <= wr_total + 1;
                end else begin
                    mem_rdata <= mem[mem_addr];
                    rd_cnt[mem_addr] <= rd_cnt[mem_addr] + 1;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [6:0] mk(input logic wm, input logic zb, input logic za, input logic [3:0] n);
        return {wm, zb, za, n};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < MEM; i++) begin
            mem[i] = '0;
            rd_cnt[i] = 0;
        end
        acc_total = 0;
        wr_total = 0;
    endtask

    task automatic run_op(input logic [2:0] len, input int a, input int b);
        @(negedge clk);
        instr_len = len;
        a_addr_in = ADDR_W'(a);
        b_addr_in = ADDR_W'(b);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 2000 && !(done || error); k++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R13 reset done", done, 0);
        chk("R13 reset error", error, 0);
        chk("R13 reset mem_en", mem_en, 0);
    endtask

    task automatic t_short_source();
        clear_all();
        mem[20] = mk(1, 0, 0, 4'd0);
        mem[21] = mk(0, 0, 1, 4'd3);
        mem[22] = mk(0, 0, 0, 4'd5);
        mem[19] = mk(0, 0, 0, 4'd9);
        mem[50] = mk(1, 1, 1, 4'd7);
        for (int i = 51; i <= 54; i++) mem[i] = mk(0, 1, 0, 4'd9);
        run_op(3'd7, 22, 54);
        chk("R3 done", done, 1);
        chk("R7 units plus", mem[54], 7'b0_11_0101);
        chk("R6 zone stripped", mem[53], 7'b0_00_0011);
        chk("R8 blank kept", mem[52], 7'b0_00_0000);
        chk("R4 zero fill", mem[51], 7'b0_00_1010);
        chk("R9 R4 mark kept with zero", mem[50], 7'b1_00_1010);
        chk("R4 no read past mark", rd_cnt[19], 0);
        chk("R12 final A", a_reg, 19);
        chk("R12 R2 final B", b_reg, 49);
    endtask

    task automatic t_chained();
        mem[17] = mk(1, 0, 0, 4'd8);
        mem[18] = mk(0, 1, 0, 4'd6);
        mem[19] = mk(0, 1, 1, 4'd2);
        mem[47] = mk(1, 0, 0, 4'd0);
        mem[48] = '0;
        mem[49] = '0;
        run_op(3'd1, 5, 5);
        chk("R12 chained done", done, 1);
        chk("R7 units zone 11", mem[49], 7'b0_11_0010);
        chk("R6 chained strip", mem[48], 7'b0_00_0110);
        chk("R3 chained last", mem[47], 7'b1_00_1000);
        chk("R12 chained A", a_reg, 16);
        chk("R12 chained B", b_reg, 46);
        chk("R3 nothing below mark", mem[46], 7'b0_00_0000);
    endtask

    task automatic t_long_source();
        clear_all();
        mem[30] = mk(1, 0, 1, 4'd1);
        mem[31] = mk(0, 0, 1, 4'd2);
        mem[32] = mk(0, 0, 1, 4'd8);
        mem[33] = mk(0, 1, 1, 4'd1);
        mem[34] = mk(0, 0, 1, 4'd4);
        mem[35] = mk(0, 1, 0, 4'd7);
        mem[60] = mk(1, 0, 0, 4'd0);
        run_op(3'd7, 35, 62);
        chk("R7 minus kept", mem[62], 7'b0_10_0111);
        chk("R6 long strip", mem[61], 7'b0_00_0100);
        chk("R3 R9 long end", mem[60], 7'b1_00_0001);
        chk("R5 excess unread", rd_cnt[32] + rd_cnt[31] + rd_cnt[30], 0);
        chk("R12 long A", a_reg, 32);
        chk("R12 long B", b_reg, 59);
    endtask

    task automatic t_one_address();
        clear_all();
        mem[80] = mk(1, 1, 0, 4'd1);
        mem[81] = mk(0, 1, 1, 4'd4);
        mem[82] = mk(0, 0, 1, 4'd9);
        run_op(3'd4, 82, 7);
        chk("R10 done", done, 1);
        chk("R10 units", mem[82], 7'b0_11_1001);
        chk("R10 middle", mem[81], 7'b0_00_0100);
        chk("R10 high", mem[80], 7'b1_00_0001);
        chk("R10 A", a_reg, 79);
        chk("R10 B", b_reg, 79);
        chk("R10 below untouched", rd_cnt[79], 0);
        repeat (5) @(negedge clk);
        chk("R13 done held", done, 1);
        chk("R13 no error", error, 0);
    endtask

    task automatic t_bad_len();
        logic [ADDR_W-1:0] a0, b0;
        clear_all();
        a0 = a_reg;
        b0 = b_reg;
        run_op(3'd5, 10, 20);
        @(negedge clk);
        chk("R1 error", error, 1);
        chk("R1 code", err_code, 1);
        chk("R1 no access", acc_total, 0);
        chk("R1 A kept", a_reg, a0);
        chk("R1 B kept", b_reg, b0);
        chk("R13 done cleared", done, 0);
        repeat (3) @(negedge clk);
        chk("R13 error held", error, 1);
    endtask

    task automatic t_bad_b();
        clear_all();
        mem[10] = mk(1, 0, 0, 4'd3);
        run_op(3'd7, 10, 250);
        chk("R11 B error", error, 1);
        chk("R11 B code", err_code, 3);
        chk("R11 B no write", wr_total, 0);
    endtask

    task automatic t_bad_a();
        clear_all();
        run_op(3'd7, 250, 60);
        chk("R11 A code", err_code, 2);
        chk("R11 A no access", acc_total, 0);
    endtask

    task automatic t_underflow();
        clear_all();
        mem[0]   = mk(0, 0, 0, 4'd4);
        mem[100] = mk(1, 0, 0, 4'd0);
        run_op(3'd7, 0, 102);
        chk("R11 wrap code", err_code, 2);
        chk("R11 units stored", mem[102], 7'b0_11_0100);
        chk("R11 next untouched", mem[101], 7'b0_00_0000);
    endtask

    initial begin
        clear_all();
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_short_source();
        t_chained();
        t_long_source();
        t_one_address();
        t_bad_len();
        t_bad_b();
        t_bad_a();
        t_underflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule